// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block keeps one small private direct-mapped cache coherent with its peers on a shared snooping bus. Each line holds a tag, a data word and one of four coherence states: Modified, Exclusive, Shared or Invalid. Modified and Exclusive lines are held by this cache alone. Modified data differs from memory, while Exclusive data matches it. Shared lines match memory and may also be held by other caches. The processor side issues one load or store at a time. It waits for a one-cycle completion pulse, and for a load that pulse carries the data.

The block puts a transaction on the bus in only three cases: a read miss, a write miss (sent as a read-with-intent-to-modify), and a store to a Shared line (sent as an upgrade that invalidates other copies). A write-back of a dirty victim comes before the miss request that displaced it. The block also watches the transactions its peers place on the bus. When a peer read hits a valid line here, the block raises the shared line and keeps its copy as Shared. When a peer write hits, the copy is dropped. In both cases a dirty line hands its data out in the same cycle, so memory and the requester see the latest value.

Each bus grant is a complete one-cycle transaction. Read data and the peers' shared and flush responses are valid during that cycle. Bus arbitration and the memory are outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, and `bus_req` and `cpu_done` are low.
- R2: A load that hits a valid line completes with no bus request, returns the line's data, and raises `cpu_done` for exactly one cycle.
- R3: A load miss issues a read (`bus_cmd` = 1) for the requested address. The line fills as Shared if `bus_shared_in` is high in the granted cycle and as Exclusive otherwise. A later store to an Exclusive line makes no bus request, while a store to a Shared line does.
- R4: A store miss issues a read-with-intent-to-modify (`bus_cmd` = 2). A store hitting a Shared line issues an upgrade (`bus_cmd` = 3). A store hitting an Exclusive or Modified line completes locally with no bus request.
- R5: A miss whose victim line is Modified first issues a write-back (`bus_cmd` = 4) carrying the victim's address and data, then issues the miss request.
- R6: A peer read (`snp_cmd` = 1) that hits a valid line raises `snp_hit` in that cycle and leaves the line Shared. If the line was Modified, `snp_flush` is raised with the line's data in the same cycle.
- R7: A peer read-with-intent-to-modify or upgrade (`snp_cmd` = 2 or 3) that hits a valid line makes it Invalid. A Modified line flushes its data in that cycle.
- R8: A snoop that misses the cache, or any peer write-back (`snp_cmd` = 4), raises neither `snp_hit` nor `snp_flush` and changes no line state.
- R9: Once raised, `bus_req` stays high until granted, and `cpu_done` stays low until every bus transaction the request needs has been granted.
- R10: In a system of such caches, at most one cache holds a writable copy of an address, and every load returns the most recently stored value.
- R11: A snoop takes precedence over local completion in the same cycle. An upgrade whose Shared line was invalidated while it waited is reissued as a read-with-intent-to-modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, accepted while `cpu_ready` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; a granted cycle is the whole transaction |
| bus_cmd | output | 3 | 0 idle, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data in the granted cycle |
| bus_shared_in | input | 1 | A peer holds the line (read transactions) |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_cmd | input | 3 | The peer's command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | The peer's address |
| snp_hit | output | 1 | Shared response to a peer read |
| snp_flush | output | 1 | Dirty data is being supplied |
| snp_data | output | DATA_W | Flushed data |

## Verification
The bench goes after the transitions where a wrong design would go quietly stale. A read snoop must leave a Modified copy Shared: a design that dropped it to Invalid would cost an extra miss, and one that kept it Modified would make the peer's later upgrade invisible. A dirty victim must be written back before its miss: skipping that loses the store, and a later load elsewhere reads stale memory. Two caches storing the same address in the same cycle, from Invalid and again from Shared, expose a design that completes a stale upgrade: its final value is wrong, or the reissued command is not a read-for-ownership. Snoops to absent lines and to write-backs are checked against a later silent hit on the untouched line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_EXC = 2'b10,
    LN_MOD = 2'b11
  } line_st_e;

  typedef enum logic [2:0] {
    BC_IDLE  = 3'd0,
    BC_READ  = 3'd1,
    BC_RWITM = 3'd2,
    BC_UPGR  = 3'd3,
    BC_WBACK = 3'd4
  } bus_cmd_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_BUSY = 1'b1
  } fsm_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lw_en,
  input  logic [IDX_W-1:0]             lw_idx,
  input  line_st_e                     lw_state,
  input  logic [TAG_W-1:0]             lw_tag,
  input  logic [DATA_W-1:0]            lw_data,
  input  logic                         sw_en,
  input  logic [IDX_W-1:0]             sw_idx,
  input  line_st_e                     sw_state,
  output line_st_e [LINES-1:0]         st_o,
  output logic [LINES-1:0][TAG_W-1:0]  tag_o,
  output logic [LINES-1:0][DATA_W-1:0] data_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              loc_sel, snp_sel;

    assign loc_sel = lw_en && (lw_idx == IDX_W'(g));
    assign snp_sel = sw_en && (sw_idx == IDX_W'(g));

    // snoop updates win over local ones
    always_comb begin
      st_d = st_q;
      if (snp_sel)      st_d = sw_state;
      else if (loc_sel) st_d = lw_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LN_INV;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (loc_sel && !snp_sel) begin
        tag_q  <= lw_tag;
        data_q <= lw_data;
      end
    end

    assign st_o[g]   = st_q;
    assign tag_o[g]  = tag_q;
    assign data_o[g] = data_q;
  end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         snp_valid,
  input  logic [2:0]                   snp_cmd,
  input  logic [ADDR_W-1:0]            snp_addr,
  input  line_st_e [LINES-1:0]         st_i,
  input  logic [LINES-1:0][TAG_W-1:0]  tag_i,
  input  logic [LINES-1:0][DATA_W-1:0] data_i,
  output logic                         snp_hit,
  output logic                         snp_flush,
  output logic [DATA_W-1:0]            snp_data,
  output logic                         sw_en,
  output logic [IDX_W-1:0]             sw_idx,
  output line_st_e                     sw_state
);

  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  line_st_e         s_st;
  logic             s_match, is_rd, is_inv;

  assign s_idx   = snp_addr[IDX_W-1:0];
  assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
  assign s_st    = st_i[s_idx];
  assign s_match = snp_valid && (s_st != LN_INV) && (tag_i[s_idx] == s_tag);
  assign is_rd   = (snp_cmd == BC_READ);
  assign is_inv  = (snp_cmd == BC_RWITM) || (snp_cmd == BC_UPGR);

  always_comb begin
    snp_hit   = s_match && is_rd;
    snp_flush = s_match && (s_st == LN_MOD) && (is_rd || is_inv);
    snp_data  = data_i[s_idx];
    sw_en     = s_match && (is_rd || is_inv);
    sw_idx    = s_idx;
    sw_state  = is_rd ? LN_SHR : LN_INV;
  end

  // R6
  rd_snoop_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && is_rd && snp_hit) |=> (st_i[$past(s_idx)] == LN_SHR));

  // R7
  inv_snoop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && is_inv && s_match) |=> (st_i[$past(s_idx)] == LN_INV));

  // R8
  snoop_miss_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !s_match) |=> $stable(st_i));

endmodule

// File: rtl/mesi_proc_fsm.sv
module mesi_proc_fsm
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic                         cpu_ready,
  output logic                         cpu_done,
  output logic [DATA_W-1:0]            cpu_rdata,
  input  logic                         snp_valid,
  output logic                         bus_req,
  input  logic                         bus_gnt,
  output logic [2:0]                   bus_cmd,
  output logic [ADDR_W-1:0]            bus_addr,
  output logic [DATA_W-1:0]            bus_wdata,
  input  logic [DATA_W-1:0]            bus_rdata,
  input  logic                         bus_shared_in,
  input  line_st_e [LINES-1:0]         st_i,
  input  logic [LINES-1:0][TAG_W-1:0]  tag_i,
  input  logic [LINES-1:0][DATA_W-1:0] data_i,
  output logic                         lw_en,
  output logic [IDX_W-1:0]             lw_idx,
  output line_st_e                     lw_state,
  output logic [TAG_W-1:0]             lw_tag,
  output logic [DATA_W-1:0]            lw_data
);

  fsm_e              fsm_q, fsm_d;
  logic              done_q, done_d;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q, rdata_q, rdata_d;
  logic              accept, rdata_en;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  line_st_e          cur_st;
  logic [TAG_W-1:0]  cur_tag;
  logic [DATA_W-1:0] cur_data;
  logic              tag_hit, local_rd, local_wr;
  bus_cmd_e          cmd_w;

  assign accept   = (fsm_q == FS_IDLE) && cpu_req;
  assign req_idx  = req_addr_q[IDX_W-1:0];
  assign req_tag  = req_addr_q[ADDR_W-1:IDX_W];
  assign cur_st   = st_i[req_idx];
  assign cur_tag  = tag_i[req_idx];
  assign cur_data = data_i[req_idx];
  assign tag_hit  = (cur_st != LN_INV) && (cur_tag == req_tag);
  assign local_rd = tag_hit && !req_we_q;
  assign local_wr = tag_hit && req_we_q && ((cur_st == LN_EXC) || (cur_st == LN_MOD));

  always_comb begin
    fsm_d     = fsm_q;
    done_d    = 1'b0;
    rdata_d   = rdata_q;
    rdata_en  = 1'b0;
    bus_req   = 1'b0;
    cmd_w     = BC_IDLE;
    bus_addr  = req_addr_q;
    bus_wdata = cur_data;
    lw_en     = 1'b0;
    lw_idx    = req_idx;
    lw_state  = cur_st;
    lw_tag    = req_tag;
    lw_data   = cur_data;
    case (fsm_q)
      FS_IDLE: if (cpu_req) fsm_d = FS_BUSY;
      FS_BUSY: begin
        if (local_rd || local_wr) begin
          if (!snp_valid) begin
            done_d = 1'b1;
            fsm_d  = FS_IDLE;
            if (local_rd) begin
              rdata_d  = cur_data;
              rdata_en = 1'b1;
            end else begin
              lw_en    = 1'b1;
              lw_state = LN_MOD;
              lw_data  = req_wdata_q;
            end
          end
        end else begin
          bus_req = 1'b1;
          if (tag_hit)                cmd_w = BC_UPGR;
          else if (cur_st == LN_MOD)  cmd_w = BC_WBACK;
          else if (req_we_q)          cmd_w = BC_RWITM;
          else                        cmd_w = BC_READ;
          if (cmd_w == BC_WBACK) bus_addr = {cur_tag, req_idx};
          if (bus_gnt) begin
            lw_en = 1'b1;
            case (cmd_w)
              BC_WBACK: begin
                lw_state = LN_INV;
                lw_tag   = cur_tag;
              end
              BC_READ: begin
                lw_state = bus_shared_in ? LN_SHR : LN_EXC;
                lw_data  = bus_rdata;
                rdata_d  = bus_rdata;
                rdata_en = 1'b1;
                done_d   = 1'b1;
                fsm_d    = FS_IDLE;
              end
              default: begin
                lw_state = LN_MOD;
                lw_data  = req_wdata_q;
                done_d   = 1'b1;
                fsm_d    = FS_IDLE;
              end
            endcase
          end
        end
      end
      default: fsm_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= FS_IDLE;
      done_q <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_we_q    <= cpu_we;
      req_addr_q  <= cpu_addr;
      req_wdata_q <= cpu_wdata;
    end
    if (rdata_en) rdata_q <= rdata_d;
  end

  assign cpu_ready = (fsm_q == FS_IDLE);
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign bus_cmd   = cmd_w;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R11
  snoop_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !cpu_done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req);

  // R3
  fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_req && cmd_w == BC_READ) |=>
      (st_i[$past(req_idx)] == ($past(bus_shared_in) ? LN_SHR : LN_EXC)));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  line_st_e [LINES-1:0]         st_w;
  logic [LINES-1:0][TAG_W-1:0]  tag_w;
  logic [LINES-1:0][DATA_W-1:0] data_w;
  logic                         lw_en, sw_en;
  logic [IDX_W-1:0]             lw_idx, sw_idx;
  line_st_e                     lw_state, sw_state;
  logic [TAG_W-1:0]             lw_tag;
  logic [DATA_W-1:0]            lw_data;

  mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lw_en    (lw_en),
    .lw_idx   (lw_idx),
    .lw_state (lw_state),
    .lw_tag   (lw_tag),
    .lw_data  (lw_data),
    .sw_en    (sw_en),
    .sw_idx   (sw_idx),
    .sw_state (sw_state),
    .st_o     (st_w),
    .tag_o    (tag_w),
    .data_o   (data_w)
  );

  mesi_snoop_unit #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_snoop (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .st_i      (st_w),
    .tag_i     (tag_w),
    .data_i    (data_w),
    .snp_hit   (snp_hit),
    .snp_flush (snp_flush),
    .snp_data  (snp_data),
    .sw_en     (sw_en),
    .sw_idx    (sw_idx),
    .sw_state  (sw_state)
  );

  mesi_proc_fsm #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_ready     (cpu_ready),
    .cpu_done      (cpu_done),
    .cpu_rdata     (cpu_rdata),
    .snp_valid     (snp_valid),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_shared_in (bus_shared_in),
    .st_i          (st_w),
    .tag_i         (tag_w),
    .data_i        (data_w),
    .lw_en         (lw_en),
    .lw_idx        (lw_idx),
    .lw_state      (lw_state),
    .lw_tag        (lw_tag),
    .lw_data       (lw_data)
  );

endmodule

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic          rq_a = 0, rq_b = 0, we_a = 0, we_b = 0;
  logic [AW-1:0] ad_a = 0, ad_b = 0;
  logic [DW-1:0] wd_a = 0, wd_b = 0;

  logic          rdy_a, rdy_b, dn_a, dn_b, breq_a, breq_b, hit_a, hit_b, fl_a, fl_b;
  logic [DW-1:0] rd_a, rd_b, bwd_a, bwd_b, sd_a, sd_b;
  logic [2:0]    cmd_a, cmd_b;
  logic [AW-1:0] badr_a, badr_b;
  logic          gnt_a, gnt_b;
  logic [DW-1:0] fill_a, fill_b;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  assign gnt_a  = breq_a;
  assign gnt_b  = breq_b && !breq_a;
  assign fill_a = fl_b ? sd_b : mem[badr_a];
  assign fill_b = fl_a ? sd_a : mem[badr_b];

  mesi_line_ctrl #(.LINES(NL), .ADDR_W(AW), .DATA_W(DW)) u_mesi_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(rq_a), .cpu_we(we_a), .cpu_addr(ad_a), .cpu_wdata(wd_a),
    .cpu_ready(rdy_a), .cpu_done(dn_a), .cpu_rdata(rd_a),
    .bus_req(breq_a), .bus_gnt(gnt_a), .bus_cmd(cmd_a), .bus_addr(badr_a),
    .bus_wdata(bwd_a), .bus_rdata(fill_a), .bus_shared_in(hit_b),
    .snp_valid(gnt_b), .snp_cmd(cmd_b), .snp_addr(badr_b),
    .snp_hit(hit_a), .snp_flush(fl_a), .snp_data(sd_a)
  );

  mesi_line_ctrl #(.LINES(NL), .ADDR_W(AW), .DATA_W(DW)) u_mesi_line_ctrl_peer (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(rq_b), .cpu_we(we_b), .cpu_addr(ad_b), .cpu_wdata(wd_b),
    .cpu_ready(rdy_b), .cpu_done(dn_b), .cpu_rdata(rd_b),
    .bus_req(breq_b), .bus_gnt(gnt_b), .bus_cmd(cmd_b), .bus_addr(badr_b),
    .bus_wdata(bwd_b), .bus_rdata(fill_b), .bus_shared_in(hit_a),
    .snp_valid(gnt_a), .snp_cmd(cmd_a), .snp_addr(badr_a),
    .snp_hit(hit_b), .snp_flush(fl_b), .snp_data(sd_b)
  );

  // transaction log, one entry per granted bus cycle
  int            log_n = 0;
  int            lg_who  [64];
  logic [2:0]    lg_cmd  [64];
  logic [AW-1:0] lg_addr [64];
  logic [DW-1:0] lg_wd   [64];
  logic          lg_hit  [64];
  logic          lg_fl   [64];
  logic [DW-1:0] lg_fd   [64];

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(16'h1000 + a * 7);
  endfunction

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = init_val(i);
  end

  always @(posedge clk) begin
    if (gnt_a) begin
      if (fl_b) mem[badr_a] <= sd_b;
      if (cmd_a == 3'd4) mem[badr_a] <= bwd_a;
    end else if (gnt_b) begin
      if (fl_a) mem[badr_b] <= sd_a;
      if (cmd_b == 3'd4) mem[badr_b] <= bwd_b;
    end
    if ((gnt_a || gnt_b) && log_n < 64) begin
      lg_who[log_n]  <= gnt_a ? 0 : 1;
      lg_cmd[log_n]  <= gnt_a ? cmd_a : cmd_b;
      lg_addr[log_n] <= gnt_a ? badr_a : badr_b;
      lg_wd[log_n]   <= gnt_a ? bwd_a : bwd_b;
      lg_hit[log_n]  <= gnt_a ? hit_b : hit_a;
      lg_fl[log_n]   <= gnt_a ? fl_b : fl_a;
      lg_fd[log_n]   <= gnt_a ? sd_b : sd_a;
      log_n <= log_n + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired got %0d exp <20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic chk_ent(input string req, input int i, input int who, input int cmd, input int addr);
    chk({req, " who"}, 32'(lg_who[i]), 32'(who));
    chk({req, " cmd"}, 32'(lg_cmd[i]), 32'(cmd));
    chk({req, " addr"}, 32'(lg_addr[i]), 32'(addr));
  endtask

  task automatic op(input int who, input logic we, input logic [AW-1:0] a,
                    input logic [DW-1:0] wd, output logic [DW-1:0] rd, output int lat);
    int t;
    @(negedge clk);
    if (who == 0) begin rq_a = 1; we_a = we; ad_a = a; wd_a = wd; end
    else          begin rq_b = 1; we_b = we; ad_b = a; wd_b = wd; end
    @(negedge clk);
    rq_a = 0;
    rq_b = 0;
    t = 0;
    while (!(who == 0 ? dn_a : dn_b) && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk("R9 request completes", 32'(t < 100), 32'd1);
    rd  = (who == 0) ? rd_a : rd_b;
    lat = t;
  endtask

  task automatic dual_store(input logic [AW-1:0] a, input logic [DW-1:0] va, input logic [DW-1:0] vb);
    int t;
    bit sa, sb;
    @(negedge clk);
    rq_a = 1; we_a = 1; ad_a = a; wd_a = va;
    rq_b = 1; we_b = 1; ad_b = a; wd_b = vb;
    @(negedge clk);
    rq_a = 0;
    rq_b = 0;
    t = 0; sa = 0; sb = 0;
    while (!(sa && sb) && t < 100) begin
      if (dn_a) sa = 1;
      if (dn_b) sb = 1;
      if (!(sa && sb)) begin
        @(negedge clk);
        t++;
      end
    end
    chk("R10 both racing stores complete", 32'(sa && sb), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 ready A", 32'(rdy_a), 32'd1);
    chk("R1 ready B", 32'(rdy_b), 32'd1);
    chk("R1 no bus request", 32'(breq_a | breq_b), 32'd0);
    chk("R1 no done", 32'(dn_a | dn_b), 32'd0);
  endtask

  task automatic t_read_fill();
    logic [DW-1:0] r;
    int lat, base;
    base = log_n;
    op(0, 0, 8'h10, 0, r, lat);
    chk("R3 load miss data", 32'(r), 32'(init_val(8'h10)));
    chk("R3 one transaction", 32'(log_n - base), 32'd1);
    chk_ent("R3 read miss", base, 0, 1, 8'h10);
    base = log_n;
    op(0, 0, 8'h10, 0, r, lat);
    chk("R2 load hit data", 32'(r), 32'(init_val(8'h10)));
    chk("R2 load hit silent", 32'(log_n - base), 32'd0);
    op(0, 1, 8'h10, 16'hAAAA, r, lat);
    chk("R4 store on exclusive silent", 32'(log_n - base), 32'd0);
  endtask

  task automatic t_read_snoop();
    logic [DW-1:0] r;
    int lat, base;
    base = log_n;
    op(1, 0, 8'h10, 0, r, lat);
    chk("R10 peer load sees dirty value", 32'(r), 32'hAAAA);
    chk_ent("R6 peer read", base, 1, 1, 8'h10);
    chk("R6 shared raised", 32'(lg_hit[base]), 32'd1);
    chk("R6 flush raised", 32'(lg_fl[base]), 32'd1);
    chk("R6 flush data", 32'(lg_fd[base]), 32'hAAAA);
    base = log_n;
    op(0, 0, 8'h10, 0, r, lat);
    chk("R6 copy kept shared", 32'(log_n - base), 32'd0);
    chk("R6 shared copy data", 32'(r), 32'hAAAA);
    op(1, 1, 8'h10, 16'hBBBB, r, lat);
    chk("R4 store on shared count", 32'(log_n - base), 32'd1);
    chk_ent("R3 shared fill needs upgrade", base, 1, 3, 8'h10);
    chk("R7 upgrade no flush from clean", 32'(lg_fl[base]), 32'd0);
  endtask

  task automatic t_inv_snoop();
    logic [DW-1:0] r;
    int lat, base;
    base = log_n;
    op(0, 0, 8'h10, 0, r, lat);
    chk_ent("R7 invalidated copy misses", base, 0, 1, 8'h10);
    chk("R7 modified peer flushes", 32'(lg_fl[base]), 32'd1);
    chk("R10 load after upgrade", 32'(r), 32'hBBBB);
  endtask

  task automatic t_victim();
    logic [DW-1:0] r;
    int lat, base;
    base = log_n;
    op(0, 1, 8'h11, 16'h1111, r, lat);
    chk_ent("R4 store miss", base, 0, 2, 8'h11);
    base = log_n;
    op(0, 1, 8'h15, 16'h1515, r, lat);
    chk("R5 two transactions", 32'(log_n - base), 32'd2);
    chk_ent("R5 write-back first", base, 0, 4, 8'h11);
    chk("R5 write-back data", 32'(lg_wd[base]), 32'h1111);
    chk_ent("R5 then ownership read", base + 1, 0, 2, 8'h15);
    chk("R9 done waits for both grants", 32'(lat), 32'd2);
    base = log_n;
    op(1, 0, 8'h11, 0, r, lat);
    chk("R5 memory holds victim data", 32'(r), 32'h1111);
    chk("R8 absent line no hit", 32'(lg_hit[base]), 32'd0);
    chk("R8 absent line no flush", 32'(lg_fl[base]), 32'd0);
  endtask

  task automatic t_miss_snoop();
    logic [DW-1:0] r;
    int lat, base;
    op(1, 1, 8'h11, 16'h2222, r, lat);
    base = log_n;
    op(1, 0, 8'h19, 0, r, lat);
    chk_ent("R8 peer write-back", base, 1, 4, 8'h11);
    chk("R8 write-back snoop no hit", 32'(lg_hit[base]), 32'd0);
    chk("R8 write-back snoop no flush", 32'(lg_fl[base]), 32'd0);
    chk("R8 peer fill data", 32'(r), 32'(init_val(8'h19)));
    base = log_n;
    op(0, 0, 8'h15, 0, r, lat);
    chk("R8 untouched line still hits", 32'(log_n - base), 32'd0);
    chk("R8 untouched line data", 32'(r), 32'h1515);
  endtask

  task automatic t_race();
    logic [DW-1:0] r;
    int lat, base;
    base = log_n;
    dual_store(8'h33, 16'h3A3A, 16'h3B3B);
    chk("R10 race transactions", 32'(log_n - base), 32'd2);
    chk_ent("R10 first owner", base, 0, 2, 8'h33);
    chk_ent("R10 second owner", base + 1, 1, 2, 8'h33);
    chk("R7 first owner flushes", 32'(lg_fd[base + 1]), 32'h3A3A);
    op(0, 0, 8'h33, 0, r, lat);
    chk("R10 last store wins", 32'(r), 32'h3B3B);
    base = log_n;
    dual_store(8'h33, 16'h4A4A, 16'h4B4B);
    chk_ent("R11 upgrade wins", base, 0, 3, 8'h33);
    chk_ent("R11 stale upgrade reissued", base + 1, 1, 2, 8'h33);
    chk("R11 upgraded line flushed", 32'(lg_fd[base + 1]), 32'h4A4A);
    op(0, 0, 8'h33, 0, r, lat);
    chk("R10 load after upgrade race", 32'(r), 32'h4B4B);
    base = log_n;
    op(1, 0, 8'h33, 0, r, lat);
    chk("R10 peer keeps shared copy", 32'(log_n - base), 32'd0);
    chk("R10 peer data", 32'(r), 32'h4B4B);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_fill();
    t_read_snoop();
    t_inv_snoop();
    t_victim();
    t_miss_snoop();
    t_race();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule